// File: doc/BRIEF.md
# Fast Ethernet receive symbol decoder

This block sits behind the slicer and clock recovery of a 100 Mb/s twisted-pair or fiber receiver. Every 125 MHz clock it takes one line symbol, undoes the line coding and hands MII-style receive nibbles to the MAC. In copper mode the symbol is a three-level MLT3 value. It is turned into NRZI, then into NRZ, and descrambled with a keystream that the block recovers by itself from the idle stream. In fiber mode the input is an NRZI bit, and the MLT3 and descrambling stages are skipped.

The descrambled bit stream is searched for the start-of-stream delimiter, which fixes the 5-bit code-group boundary. Each group that follows is decoded to a nibble until the end delimiter arrives. `nib_vld_o` pulses once per decoded group, and `rx_dv_o` and `rx_er_o` frame the data.

Top module: `fe_rx_decoder`

## Requirements
- R1: In copper mode, any change of `mlt3_i` from the previous clock is taken as NRZI 1 and no change as 0. Any change of the NRZI value from the previous clock is taken as NRZ 1. Level codes are 2'b00 zero, 2'b01 positive and 2'b11 negative.
- R2: The copper descrambler removes a keystream obeying k[n] = k[n-11] XOR k[n-9]. While unlocked it loads the keystream from received bits, assuming plain idle ones. `lock_o` rises only after 30 consecutive bits that the keystream predicted correctly, so it is still low after 29 received bits.
- R3: With `fiber_i` high, `nrzi_i` is used directly, no keystream is removed, and `lock_o` is high from reset.
- R4: Alignment is set by the delimiter pair 11000 then 10001, each group sent first bit left. The next group is the first data nibble. Groups map 11110,01001,10100,10101,01010,01011,01110,01111,10010,10011,10110,10111,11010,11011,11100,11101 to nibbles 0 through F. `rx_dv_o` rises with the first data nibble.
- R5: The group 01101 ends the frame. `rx_dv_o` falls and no nibble is emitted for it or for the group after it.
- R6: A group that is not a data code, not 01101 and not 11111 emits a nibble with `rx_er_o` high, and the frame continues.
- R7: The idle group 11111 inside a frame emits one nibble with `rx_er_o` high and ends the frame.
- R8: Between frames, a zero bit that does not complete the delimiter pair within the next 7 bits drops `lock_o`. No nibble is emitted until lock has been regained and a new delimiter pair is seen.
- R9: After reset `rx_dv_o`, `rx_er_o`, `nib_vld_o` and copper-mode `lock_o` are low.
- R10: `nib_vld_o` is never high on two consecutive clocks, and `rx_er_o` is high only while `rx_dv_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz symbol clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fiber_i | input | 1 | 1 selects fiber input and bypass of MLT3 and descrambler |
| mlt3_i | input | 2 | Sliced MLT3 level in copper mode |
| nrzi_i | input | 1 | NRZI bit in fiber mode |
| lock_o | output | 1 | Descrambler locked (always high in fiber mode) |
| nib_vld_o | output | 1 | One-clock strobe per decoded code group |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error for the current nibble |
| rxd_o | output | 4 | Receive nibble |

## Verification
A bench-side transmitter scrambles, NRZI-encodes and MLT3-encodes frames. It sends a sweep of all sixteen nibble values and a run of all 256 byte values, which separate a wrong code table, a wrong bit order or a wrong keystream tap. The same frames go through fiber mode, which shows the bypass path is independent of the scrambler. Frames with an illegal group, with idle cutting the frame short, and a burst of zeros between frames show error marking, premature end and forced relock. Counting idle bits before lock separates the 30-bit threshold from an early lock.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
  localparam int unsigned GRP_W = 5;
  localparam logic [GRP_W-1:0] GRP_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] GRP_SSD1 = 5'b11000;
  localparam logic [GRP_W-1:0] GRP_SSD2 = 5'b10001;
  localparam logic [GRP_W-1:0] GRP_ESD1 = 5'b01101;

  typedef enum logic [1:0] {AL_IDLE, AL_CHECK, AL_FRAME, AL_END} al_state_e;

  typedef struct packed {
    logic       ok;
    logic [3:0] nib;
  } dec_t;

  function automatic dec_t dec_grp(input logic [GRP_W-1:0] g);
    dec_t d;
    d.ok = 1'b1;
    unique case (g)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.ok  = 1'b0;
        d.nib = 4'h0;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/fe_rx_line.sv
module fe_rx_line #(
  parameter int unsigned LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fiber_i,
  input  logic [LVL_W-1:0] mlt3_i,
  input  logic             nrzi_i,
  output logic             nrz_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             nrzi_q;
  logic             nrzi_bit;

  // copper: level change = NRZI 1
  always_comb nrzi_bit = fiber_i ? nrzi_i : (mlt3_i != lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      nrzi_q <= 1'b0;
      nrz_o  <= 1'b1;
    end else begin
      lvl_q  <= mlt3_i;
      nrzi_q <= nrzi_bit;
      nrz_o  <= nrzi_bit ^ nrzi_q;
    end
  end
endmodule

// File: rtl/fe_rx_descr.sv
module fe_rx_descr #(
  parameter int unsigned LFSR_W   = 11,
  parameter int unsigned TAP      = 9,
  parameter int unsigned LOCK_RUN = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic relock_i,
  input  logic bit_i,
  output logic bit_o,
  output logic lock_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_RUN + 1);

  logic [LFSR_W-1:0] sr_q;
  logic [CNT_W-1:0]  run_q;
  logic              lock_q;
  logic              key;
  logic              idle_key;

  always_comb begin
    key      = sr_q[LFSR_W-1] ^ sr_q[TAP-1];
    idle_key = ~bit_i;  // keystream bit if plain bit was idle 1
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
      bit_o  <= 1'b1;
    end else begin
      bit_o <= bypass_i ? bit_i : (bit_i ^ key);
      if (relock_i) begin
        lock_q <= 1'b0;
        run_q  <= '0;
        sr_q   <= {sr_q[LFSR_W-2:0], idle_key};
      end else if (!lock_q) begin
        sr_q <= {sr_q[LFSR_W-2:0], idle_key};
        if (key == idle_key) begin
          if (run_q == CNT_W'(LOCK_RUN - 1)) lock_q <= 1'b1;
          if (run_q != CNT_W'(LOCK_RUN)) run_q <= run_q + 1'b1;
        end else begin
          run_q <= '0;
        end
      end else begin
        sr_q <= {sr_q[LFSR_W-2:0], key};
      end
    end
  end

  assign lock_o = bypass_i | lock_q;
endmodule

// File: rtl/fe_rx_align.sv
module fe_rx_align
  import fe_rx_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             bit_i,
  output logic             relock_o,
  output logic             nib_vld_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  localparam int unsigned WIN_W = 2 * GRP_W - 1;
  localparam int unsigned CNT_W = 3;
  localparam logic [CNT_W-1:0] SSD_TAIL = CNT_W'(6);
  localparam logic [CNT_W-1:0] GRP_LAST = CNT_W'(GRP_W - 1);

  al_state_e        state_q, state_d;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GRP_W-1:0] grp;
  dec_t             dec;
  logic             emit, emit_er;

  always_comb begin
    grp      = {win_q[GRP_W-2:0], bit_i};
    dec      = dec_grp(grp);
    state_d  = state_q;
    cnt_d    = cnt_q;
    emit     = 1'b0;
    emit_er  = 1'b0;
    relock_o = 1'b0;
    if (!lock_i) begin
      state_d = AL_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        AL_IDLE: if (!bit_i) begin
          state_d = AL_CHECK;
          cnt_d   = '0;
        end
        AL_CHECK: begin
          if (cnt_q == SSD_TAIL) begin
            cnt_d = '0;
            if ({win_q, bit_i} == {GRP_SSD1, GRP_SSD2}) begin
              state_d = AL_FRAME;
            end else begin
              state_d  = AL_IDLE;
              relock_o = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        AL_FRAME: begin
          if (cnt_q == GRP_LAST) begin
            cnt_d = '0;
            if (grp == GRP_ESD1) begin
              state_d = AL_END;
            end else if (grp == GRP_IDLE) begin
              emit    = 1'b1;
              emit_er = 1'b1;
              state_d = AL_IDLE;
            end else begin
              emit    = 1'b1;
              emit_er = ~dec.ok;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        AL_END: begin
          if (cnt_q == GRP_LAST) begin
            cnt_d   = '0;
            state_d = AL_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = AL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= AL_IDLE;
      cnt_q     <= '0;
      win_q     <= '1;
      nib_vld_o <= 1'b0;
      rx_dv_o   <= 1'b0;
      rx_er_o   <= 1'b0;
      rxd_o     <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      win_q     <= {win_q[WIN_W-2:0], bit_i};
      nib_vld_o <= emit;
      if (emit) begin
        rx_dv_o <= 1'b1;
        rx_er_o <= emit_er;
        rxd_o   <= dec.nib;
      end else if (state_d != AL_FRAME) begin
        rx_dv_o <= 1'b0;
        rx_er_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
  parameter int unsigned LVL_W    = 2,
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned LFSR_W   = 11,
  parameter int unsigned TAP      = 9,
  parameter int unsigned LOCK_RUN = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fiber_i,
  input  logic [LVL_W-1:0] mlt3_i,
  input  logic             nrzi_i,
  output logic             lock_o,
  output logic             nib_vld_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  logic nrz;
  logic plain;
  logic relock;

  fe_rx_line #(.LVL_W(LVL_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fiber_i(fiber_i),
    .mlt3_i (mlt3_i),
    .nrzi_i (nrzi_i),
    .nrz_o  (nrz)
  );

  fe_rx_descr #(.LFSR_W(LFSR_W), .TAP(TAP), .LOCK_RUN(LOCK_RUN)) u_descr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bypass_i(fiber_i),
    .relock_i(relock),
    .bit_i   (nrz),
    .bit_o   (plain),
    .lock_o  (lock_o)
  );

  fe_rx_align #(.NIB_W(NIB_W)) u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_o),
    .bit_i    (plain),
    .relock_o (relock),
    .nib_vld_o(nib_vld_o),
    .rx_dv_o  (rx_dv_o),
    .rx_er_o  (rx_er_o),
    .rxd_o    (rxd_o)
  );
endmodule

// File: rtl/fe_rx_decoder_sva.sv
module fe_rx_decoder_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_o,
  input logic nib_vld_o,
  input logic rx_dv_o,
  input logic rx_er_o
);
  assert_vld_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |=> !nib_vld_o);

  assert_er_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> rx_dv_o);

  assert_dv_rise_with_nib_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> nib_vld_o);

  assert_dv_fall_no_nib_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_dv_o) |-> !nib_vld_o);

  assert_nib_needs_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |-> lock_o);
endmodule

bind fe_rx_decoder fe_rx_decoder_sva u_sva (.*);

// File: tb/fe_rx_decoder_tb.sv
module fe_rx_decoder_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fiber_i = 1'b0;
  logic [1:0] mlt3_i = 2'b00;
  logic       nrzi_i = 1'b0;
  logic       lock_o, nib_vld_o, rx_dv_o, rx_er_o;
  logic [3:0] rxd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  fe_rx_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fiber_i(fiber_i), .mlt3_i(mlt3_i),
    .nrzi_i(nrzi_i), .lock_o(lock_o), .nib_vld_o(nib_vld_o),
    .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .rxd_o(rxd_o)
  );

  // transmitter model state
  logic [10:0] k_hist;
  logic        nrzi_lvl;
  logic [1:0]  mlt_idx;
  logic [3:0]  exp_nib [0:1023];
  logic        exp_er  [0:1023];
  logic [3:0]  got_nib [0:1023];
  logic        got_er  [0:1023];
  logic        got_dv  [0:1023];
  int          got_n = 0;

  always @(negedge clk_i)
    if (rst_ni && nib_vld_o && got_n < 1024) begin
      got_nib[got_n] = rxd_o;
      got_er[got_n]  = rx_er_o;
      got_dv[got_n]  = rx_dv_o;
      got_n++;
    end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100;
      4'h3: return 5'b10101; 4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111; 4'h8: return 5'b10010;
      4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  task automatic tx_bit(input logic b);
    logic key, c;
    key    = k_hist[10] ^ k_hist[8];
    k_hist = {k_hist[9:0], key};
    c      = fiber_i ? b : (b ^ key);
    nrzi_lvl = nrzi_lvl ^ c;
    if (nrzi_lvl) mlt_idx = mlt_idx + 2'd1;
    case (mlt_idx)
      2'd1:    mlt3_i = 2'b01;
      2'd3:    mlt3_i = 2'b11;
      default: mlt3_i = 2'b00;
    endcase
    nrzi_i = nrzi_lvl;
    @(negedge clk_i);
  endtask

  task automatic tx_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) tx_bit(g[i]);
  endtask

  task automatic tx_idle(input int n);
    for (int i = 0; i < n; i++) tx_bit(1'b1);
  endtask

  task automatic do_reset(input logic fib);
    @(negedge clk_i);
    rst_ni   = 1'b0;
    fiber_i  = fib;
    k_hist   = 11'h5A3;
    nrzi_lvl = 1'b0;
    mlt_idx  = 2'd0;
    mlt3_i   = 2'b00;
    nrzi_i   = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // sends J K, n groups (bad_idx replaced by 00100), then T R and idle
  task automatic send_frame(input int n, input int bad_idx);
    got_n = 0;
    tx_grp(5'b11000);
    tx_grp(5'b10001);
    for (int i = 0; i < n; i++) begin
      if (i == bad_idx) begin
        tx_grp(5'b00100);
        exp_er[i] = 1'b1;
      end else begin
        tx_grp(enc(exp_nib[i]));
        exp_er[i] = 1'b0;
      end
    end
    tx_grp(5'b01101);
    tx_grp(5'b00111);
    tx_idle(20);
  endtask

  task automatic check_frame(input string tag, input int n, input int bad_idx);
    chk({tag, " nibble count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++) begin
      if (i != bad_idx) chk({tag, " rxd"}, got_nib[i], exp_nib[i]);
      chk({tag, " R6 rx_er"}, got_er[i], exp_er[i]);
      chk({tag, " R4 rx_dv"}, got_dv[i], 1);
    end
    chk({tag, " R5 rx_dv low after end"}, rx_dv_o, 0);
  endtask

  task automatic load_sweep();
    for (int i = 0; i < 16; i++) exp_nib[i] = 4'(i);
  endtask

  task automatic load_bytes();
    for (int b = 0; b < 256; b++) begin
      exp_nib[2*b]   = 4'(b);
      exp_nib[2*b+1] = 4'(b >> 4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R9 reset state
    chk("R9 lock_o", lock_o, 0);
    chk("R9 rx_dv_o", rx_dv_o, 0);
    chk("R9 rx_er_o", rx_er_o, 0);
    chk("R9 nib_vld_o", nib_vld_o, 0);

    // R2 threshold
    tx_idle(29);
    chk("R2 no lock before 30 bits", lock_o, 0);
    tx_idle(60);
    chk("R2 lock after idle run", lock_o, 1);

    // R1 R4 copper sweep
    load_sweep();
    send_frame(16, -1);
    check_frame("R1 copper sweep", 16, -1);

    load_bytes();
    send_frame(512, -1);
    check_frame("R4 copper bytes", 512, -1);

    // R6 illegal group mid frame
    for (int i = 0; i < 7; i++) exp_nib[i] = 4'(i + 9);
    send_frame(7, 3);
    check_frame("R6 bad group", 7, 3);

    // R7 idle inside frame
    got_n = 0;
    tx_grp(5'b11000);
    tx_grp(5'b10001);
    tx_grp(enc(4'h5));
    tx_grp(enc(4'hA));
    tx_idle(30);
    chk("R7 count", got_n, 3);
    chk("R7 first", got_nib[0], 5);
    chk("R7 second", got_nib[1], 10);
    chk("R7 er on idle", got_er[2], 1);
    chk("R7 dv on idle nib", got_dv[2], 1);
    chk("R7 dv low after", rx_dv_o, 0);
    chk("R7 lock kept", lock_o, 1);

    // R8 break in idle
    tx_idle(10);
    for (int i = 0; i < 10; i++) tx_bit(1'b0);
    tx_idle(3);
    chk("R8 lock dropped", lock_o, 0);
    for (int i = 0; i < 10; i++) exp_nib[i] = 4'h0;
    send_frame(10, -1);
    chk("R8 no nibbles while unlocked", got_n, 0);
    tx_idle(80);
    chk("R8 relocked", lock_o, 1);
    load_sweep();
    send_frame(16, -1);
    check_frame("R8 after relock", 16, -1);

    // R3 fiber mode
    do_reset(1'b1);
    chk("R3 fiber lock at reset", lock_o, 1);
    tx_idle(20);
    load_sweep();
    send_frame(16, -1);
    check_frame("R3 fiber sweep", 16, -1);
    load_bytes();
    send_frame(512, -1);
    check_frame("R3 fiber bytes", 512, -1);

    // back to copper
    do_reset(1'b0);
    chk("R9 copper lock after reset", lock_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule